// File: doc/BRIEF.md
# Alphanumeric Candidate String Generator

This block enumerates every string over a 62-symbol alphanumeric alphabet, one string per request, for feeding a brute-force hashing pipeline. It holds one symbol index per character position plus a current length, and behaves like an odometer whose least significant wheel is position 0. Each accepted request advances the odometer, and the mapped ASCII bytes appear on a wide byte-vector output together with the string length and a one-cycle valid pulse.

The generator starts empty, so the first request yields a single character. Whenever every occupied position has rolled over, the string grows by one character. Once every string up to the configured maximum length has been produced, the next request raises a sticky exhaustion flag instead of producing a string. A synchronous clear restarts the enumeration from the empty string.

Top module: `cand_string_gen`

## Requirements
- R1: Symbol index i maps to ASCII as follows: 0..25 to 'a'..'z' (0x61..0x7A), 26..51 to 'A'..'Z' (0x41..0x5A), 52..61 to '0'..'9' (0x30..0x39).
- R2: After reset or clear the length is 0, and the first accepted request produces the string "a" with strLen = 1.
- R3: An accepted request scans from position 0 upward: the first occupied position whose index is below 61 is incremented and the scan stops; every occupied position at index 61 passed on the way returns to index 0.
- R4: When every occupied position is at index 61 (including the empty string), an accepted request increases the length by one and leaves every position at index 0.
- R5: When every position is at 61 and the length equals MAX_LEN, a request produces no valid pulse, raises exhausted one cycle later, and leaves strBytes and strLen unchanged.
- R6: Character position p appears on strBytes[8p+7:8p]; strLen gives the number of characters.
- R7: Bytes at positions at or beyond strLen are 0x00.
- R8: clear is synchronous, returns the length to 0, every digit to index 0 and exhausted to 0, and takes priority over a request in the same cycle (no valid pulse follows).
- R9: While exhausted is high it stays high until clear, and requests produce no valid pulse and leave the outputs unchanged.
- R10: strValid is high for exactly the cycle after each accepted request and low otherwise; requests may be presented on consecutive cycles and each is accepted.
- R11: After reset strValid, exhausted and strLen are 0 and strBytes is all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear | input | 1 | Synchronous restart of the enumeration |
| nextReq | input | 1 | Request the next string this cycle |
| strValid | output | 1 | One-cycle pulse: a new string is on the outputs |
| strBytes | output | 8*MAX_LEN | Characters, position 0 in the low byte |
| strLen | output | $clog2(MAX_LEN+1) | Current string length |
| exhausted | output | 1 | Every string has been produced |

## Verification
The bench runs the generator with a small maximum length and walks the full enumeration against an independent odometer model, so single-position increments, carry into the next position, growth from the empty string and from all-'9' strings, and the exhaustion boundary are all compared byte by byte. Requests are presented both back to back and with idle gaps, which separates a correct one-cycle valid pulse from a stuck or missing one. Clear is exercised mid-run, after exhaustion and in the same cycle as a request, which tells a proper restart with priority apart from a clear that loses to the request or leaves the sticky flag set.

// File: rtl/cand_gen_pkg.sv
package cand_gen_pkg;

  localparam int SYM_W = 6;
  localparam logic [SYM_W-1:0] SYM_LAST = 6'd61;

  // Strobes from control to datapath
  typedef struct packed {
    logic clearAll;
    logic advance;
    logic grow;
  } genStrobe_t;

  // Symbol index to ASCII: lowercase, then uppercase, then decimal digits
  function automatic logic [7:0] symToAscii(input logic [SYM_W-1:0] sym);
    logic [7:0] wide;
    wide = {2'b00, sym};
    if (sym < 6'd26)      return wide + 8'h61;
    else if (sym < 6'd52) return wide + 8'd39;
    else                  return wide - 8'd4;
  endfunction

endpackage

// File: rtl/cand_gen_dp.sv
module cand_gen_dp
  import cand_gen_pkg::*;
#(
  parameter int MAX_LEN = 58,
  parameter int LEN_W   = $clog2(MAX_LEN + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  genStrobe_t             strobe,
  output logic                   allTop,
  output logic                   atLimit,
  output logic [MAX_LEN*8-1:0]   strBytes,
  output logic [LEN_W-1:0]       strLen
);

  logic [LEN_W-1:0] lenQ;
  logic [MAX_LEN:0] carry;

  assign carry[0] = 1'b1;

  genvar p;
  generate
    for (p = 0; p < MAX_LEN; p++) begin : g_pos
      logic [SYM_W-1:0] digitQ;
      logic inRange;
      logic isTop;
      logic passes;

      assign inRange = (LEN_W'(p) < lenQ);
      assign isTop   = (digitQ == SYM_LAST);
      // Unoccupied positions pass the carry so it reaches the end
      assign passes  = inRange ? isTop : 1'b1;
      assign carry[p+1] = carry[p] & passes;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          digitQ <= '0;
        end else if (strobe.clearAll) begin
          digitQ <= '0;
        end else if (strobe.advance && inRange && carry[p]) begin
          digitQ <= isTop ? '0 : digitQ + 1'b1;
        end
      end

      assign strBytes[p*8 +: 8] = inRange ? symToAscii(digitQ) : 8'h00;
    end
  endgenerate

  // Unoccupied digits are always zero, so growth only extends the length
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lenQ <= '0;
    end else if (strobe.clearAll) begin
      lenQ <= '0;
    end else if (strobe.grow) begin
      lenQ <= lenQ + 1'b1;
    end
  end

  assign allTop  = carry[MAX_LEN];
  assign atLimit = (lenQ == LEN_W'(MAX_LEN));
  assign strLen  = lenQ;

endmodule

// File: rtl/cand_gen_ctrl.sv
module cand_gen_ctrl
  import cand_gen_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clear,
  input  logic       nextReq,
  input  logic       allTop,
  input  logic       atLimit,
  output genStrobe_t strobe,
  output logic       strValid,
  output logic       exhausted
);

  logic doneQ;
  logic validQ;
  logic accept;
  logic stall;

  assign accept = nextReq & ~doneQ & ~clear;
  assign stall  = allTop & atLimit;

  always_comb begin
    strobe.clearAll = clear;
    strobe.advance  = accept & ~stall;
    strobe.grow     = accept & ~stall & allTop;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      doneQ  <= 1'b0;
      validQ <= 1'b0;
    end else if (clear) begin
      doneQ  <= 1'b0;
      validQ <= 1'b0;
    end else begin
      validQ <= accept & ~stall;
      if (accept && stall) doneQ <= 1'b1;
    end
  end

  assign strValid  = validQ;
  assign exhausted = doneQ;

endmodule

// File: rtl/cand_string_gen.sv
module cand_string_gen
  import cand_gen_pkg::*;
#(
  parameter  int MAX_LEN = 58,
  localparam int LEN_W   = $clog2(MAX_LEN + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clear,
  input  logic                 nextReq,
  output logic                 strValid,
  output logic [MAX_LEN*8-1:0] strBytes,
  output logic [LEN_W-1:0]     strLen,
  output logic                 exhausted
);

  genStrobe_t strobe;
  logic allTop;
  logic atLimit;

  cand_gen_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (clear),
    .nextReq   (nextReq),
    .allTop    (allTop),
    .atLimit   (atLimit),
    .strobe    (strobe),
    .strValid  (strValid),
    .exhausted (exhausted)
  );

  cand_gen_dp #(
    .MAX_LEN (MAX_LEN),
    .LEN_W   (LEN_W)
  ) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe   (strobe),
    .allTop   (allTop),
    .atLimit  (atLimit),
    .strBytes (strBytes),
    .strLen   (strLen)
  );

endmodule

// File: rtl/cand_string_gen_chk.sv
module cand_string_gen_chk #(
  parameter int MAX_LEN = 58,
  parameter int LEN_W   = 6
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 clear,
  input logic                 nextReq,
  input logic                 strValid,
  input logic [MAX_LEN*8-1:0] strBytes,
  input logic [LEN_W-1:0]     strLen,
  input logic                 exhausted
);

  logic [MAX_LEN*8-1:0] beyondBits;

  always_comb begin
    beyondBits = '0;
    for (int p = 0; p < MAX_LEN; p++) begin
      if (p >= int'(strLen)) beyondBits[p*8 +: 8] = strBytes[p*8 +: 8];
    end
  end

  // R7: nothing beyond the current length
  a_r7_zero_beyond: assert property (@(posedge clk) disable iff (!rst_n)
    beyondBits == '0);

  // R5: length never exceeds the maximum
  a_r5_len_bound: assert property (@(posedge clk) disable iff (!rst_n)
    int'(strLen) <= MAX_LEN);

  // R2: first string after the empty state is "a"
  a_r2_first_a: assert property (@(posedge clk) disable iff (!rst_n)
    (strValid && $past(strLen) == '0) |-> (strLen == LEN_W'(1) && strBytes[7:0] == 8'h61));

  // R4: growth adds exactly one position and restarts position 0 at 'a'
  a_r4_grow_one: assert property (@(posedge clk) disable iff (!rst_n)
    (strValid && strLen != $past(strLen)) |-> (strLen == $past(strLen) + 1'b1 && strBytes[7:0] == 8'h61));

  // R8: clear empties the generator and suppresses the valid pulse
  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (strLen == '0 && !exhausted && !strValid));

  // R9: exhaustion is sticky until cleared
  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (exhausted && !clear) |=> exhausted);

  // R9: no strings after exhaustion
  a_r9_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    exhausted |-> !strValid);

  // R10: a valid pulse always follows a request
  a_r10_req_before_valid: assert property (@(posedge clk) disable iff (!rst_n)
    strValid |-> $past(nextReq) && !$past(clear));

endmodule

bind cand_string_gen cand_string_gen_chk #(
  .MAX_LEN (MAX_LEN),
  .LEN_W   (LEN_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .clear     (clear),
  .nextReq   (nextReq),
  .strValid  (strValid),
  .strBytes  (strBytes),
  .strLen    (strLen),
  .exhausted (exhausted)
);

// File: tb/cand_string_gen_test.sv
module cand_string_gen_test;

  localparam int TB_MAX = 2;
  localparam int TB_LW  = $clog2(TB_MAX + 1);
  localparam int TOTAL  = 62 + 62 * 62;
  localparam string ALPHA = "abcdefghijklmnopqrstuvwxyzABCDEFGHIJKLMNOPQRSTUVWXYZ0123456789";

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clear = 1'b0;
  logic nextReq = 1'b0;
  logic strValid;
  logic [TB_MAX*8-1:0] strBytes;
  logic [TB_LW-1:0] strLen;
  logic exhausted;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 1'b0;

  // Reference odometer
  int mdig[TB_MAX];
  int mlen = 0;
  bit mdone = 1'b0;
  logic [TB_MAX*8-1:0] expQ[$];
  int expLenQ[$];

  always #5 clk = ~clk;

  cand_string_gen #(.MAX_LEN(TB_MAX)) uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (clear),
    .nextReq   (nextReq),
    .strValid  (strValid),
    .strBytes  (strBytes),
    .strLen    (strLen),
    .exhausted (exhausted)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  function automatic logic [TB_MAX*8-1:0] modelBytes();
    logic [TB_MAX*8-1:0] b = '0;
    for (int p = 0; p < TB_MAX; p++)
      if (p < mlen) b[p*8 +: 8] = ALPHA[mdig[p]];
    return b;
  endfunction

  task automatic modelReset();
    for (int p = 0; p < TB_MAX; p++) mdig[p] = 0;
    mlen = 0;
    mdone = 1'b0;
  endtask

  task automatic modelStep();
    bit full = 1'b1;
    if (mdone) return;
    for (int p = 0; p < mlen; p++) if (mdig[p] != 61) full = 1'b0;
    if (full && mlen == TB_MAX) begin
      mdone = 1'b1;
      return;
    end
    for (int p = 0; p < mlen; p++) begin
      if (mdig[p] != 61) begin
        mdig[p]++;
        break;
      end
      mdig[p] = 0;
    end
    if (full) mlen++;
    expQ.push_back(modelBytes());
    expLenQ.push_back(mlen);
  endtask

  // Driver: back-to-back requests, then release
  task automatic issue(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      nextReq = 1'b1;
      modelStep();
    end
    @(negedge clk);
    nextReq = 1'b0;
  endtask

  task automatic doClear(input bit withReq);
    @(negedge clk);
    clear = 1'b1;
    nextReq = withReq;
    modelReset();
    @(negedge clk);
    clear = 1'b0;
    nextReq = 1'b0;
  endtask

  // Monitor: pop and compare on every valid pulse (R1/R3/R6/R7)
  always @(negedge clk) begin
    if (rst_n && strValid) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R10 unexpected valid", 64'(strBytes), 64'h0);
      end else begin
        logic [TB_MAX*8-1:0] eb;
        int el;
        eb = expQ.pop_front();
        el = expLenQ.pop_front();
        check(strBytes == eb, "R1/R3/R6/R7 bytes", 64'(strBytes), 64'(eb));
        check(int'(strLen) == el, "R3/R4 length", 64'(strLen), 64'(el));
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog expired", 64'h0, 64'h1);
    finishRun();
  end

  initial begin
    modelReset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11: reset state
    check(strLen == '0, "R11 length after reset", 64'(strLen), 64'h0);
    check(!strValid && !exhausted, "R11 flags after reset", {62'h0, strValid, exhausted}, 64'h0);
    check(strBytes == '0, "R11 bytes after reset", 64'(strBytes), 64'h0);

    // R2: first string
    issue(1);
    check(strValid && strBytes == 16'h0061 && strLen == 2'd1, "R2 first string a",
          64'(strBytes), 64'h61);

    // R1: end of one-character range is '9'
    issue(61);
    check(strBytes == 16'h0039 && strLen == 2'd1, "R1 last single char 9", 64'(strBytes), 64'h39);

    // R4: growth to "aa"
    issue(1);
    check(strBytes == 16'h6161 && strLen == 2'd2, "R4 growth to aa", 64'(strBytes), 64'h6161);

    // R3/R6: position 0 moves first -> "ba" (byte0 'b', byte1 'a')
    issue(1);
    check(strBytes == 16'h6162, "R3 R6 position 0 fastest", 64'(strBytes), 64'h6162);

    // R10: no request, no pulse
    @(negedge clk);
    check(!strValid, "R10 valid low when idle", 64'(strValid), 64'h0);

    // Run to the last string "99"
    issue(TOTAL - 64);
    check(strBytes == 16'h3939 && strLen == 2'd2 && !exhausted, "R5 last string 99",
          64'(strBytes), 64'h3939);

    // R5: exhaustion request
    issue(1);
    check(exhausted, "R5 exhausted raised", 64'(exhausted), 64'h1);
    check(!strValid, "R5 no valid on exhaustion", 64'(strValid), 64'h0);
    check(strBytes == 16'h3939 && strLen == 2'd2, "R5 outputs retained", 64'(strBytes), 64'h3939);

    // R9: further requests ignored
    issue(3);
    check(exhausted && !strValid, "R9 still exhausted, no valid", {62'h0, exhausted, strValid}, 64'h2);
    check(strBytes == 16'h3939, "R9 bytes unchanged", 64'(strBytes), 64'h3939);

    // R8: clear with a simultaneous request
    doClear(1'b1);
    check(strLen == '0 && !exhausted && !strValid, "R8 clear priority",
          {60'h0, strLen, exhausted, strValid}, 64'h0);
    check(strBytes == '0, "R8 R7 bytes zero after clear", 64'(strBytes), 64'h0);

    // R2 after clear
    issue(1);
    check(strBytes == 16'h0061 && strLen == 2'd1, "R2 restart at a", 64'(strBytes), 64'h61);

    // R8: clear mid-run
    issue(70);
    doClear(1'b0);
    issue(2);
    check(strBytes == 16'h0062 && strLen == 2'd1, "R8 mid-run clear restarts", 64'(strBytes), 64'h62);

    @(negedge clk);
    check(expQ.size() == 0, "R10 every request produced a string", 64'(expQ.size()), 64'h0);
    finishRun();
  end

endmodule